// File: doc/BRIEF.md
# Systolic Autocorrelation Lag Engine

This block produces the first ten autocorrelation lags of one frame of already-windowed 16-bit speech samples. It is a linear chain of multiply-accumulate cells, with one cell for each lag. A short register line holds the most recent samples. On every accepted sample, cell k multiplies the incoming sample by the sample taken k acceptances earlier and adds the product to its own running sum. All ten lags therefore build up at the same time in a single pass over the frame. No sample store and no partial-sum memory are needed.

Software or an upstream windowing stage pulses `start_i` and then streams the frame in, one sample per `sample_valid_i` strobe. Gaps between strobes are allowed. The frame length is a parameter (240 by default; 160 is another common value) and sets only how many samples are consumed, not how many cells exist. When the last sample has been taken, the ten sums appear in parallel on `lag_o` and `ready_o` rises. Both stay where they are until the next start pulse.

Top module: `acorr_systolic`

## Requirements
- R1: The cycle after `start_i` is sampled high, `ready_o` is 0 and every lag field of `lag_o` is 0.
- R2: Lag field k (bits [k*40 +: 40] of `lag_o`, two's complement) equals the sum over n = 0 to FRAME_LEN-1 of s(n)·s(n-k). Samples s(m) with m < 0 count as zero, so lag k receives its first product at sample index k.
- R3: A sample is accepted only while a frame is open, meaning after a start and before the frame completes, and only when `sample_valid_i` is high. Idle cycles within a frame do not advance the frame. Strobes while no frame is open change neither the outputs nor the later results.
- R4: `ready_o` is 0 up to and including the cycle in which the FRAME_LEN-th sample is presented, and it is 1 in the next cycle.
- R5: Once `ready_o` is 1, it and `lag_o` hold their values until the next start pulse, whatever arrives on `sample_valid_i` and `sample_i`.
- R6: A start pulse in the middle of a frame discards all partial sums and the delayed-sample history. The next result depends only on samples accepted after that pulse.
- R7: A sample strobed in the same cycle as `start_i` is not part of the new frame.
- R8: With 40-bit lag fields, a full-scale frame does not overflow. For a 240-sample frame of -32768, lag k equals (240-k)·2^30.
- R9: After reset, `ready_o` is 0, all lag fields are 0, and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole array |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new frame; clears sums and sample history |
| sample_valid_i | input | 1 | Qualifies `sample_i` in this cycle |
| sample_i | input | 16 | Windowed sample, two's complement |
| ready_o | output | 1 | All lag fields hold a finished frame |
| lag_o | output | 400 | Ten 40-bit lag sums, lag k at bits [k*40 +: 40] |

## Verification
The bench attacks the zero-fill at the start of a frame. A delay line left holding the previous frame would add cross-frame products to the higher lags, and that shows up after a back-to-back restart. It streams frames with idle gaps, so a design that counted cycles instead of accepted samples would finish early and shift the lags. It checks `ready_o` in the exact cycle it must rise, which catches an off-by-one terminal count. It pulses start in mid-frame and together with a strobe, where a leaking sample would corrupt every lag. A full-scale negative frame exposes a truncated or zero-extended product.

// File: rtl/acorr_pkg.sv
package acorr_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_RUN  = 2'd1,
    FR_DONE = 2'd2
  } frame_state_e;

endpackage

// File: rtl/acorr_frame_ctrl.sv
module acorr_frame_ctrl
  import acorr_pkg::*;
#(
  parameter int FRAME_LEN = 240
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic sample_valid_i,
  output logic accept_o,
  output logic clear_o,
  output logic ready_o
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

  frame_state_e     state_q;
  logic [CNT_W-1:0] count_q;
  logic             ready_q;
  logic             last_take;

  assign clear_o   = start_i;
  assign accept_o  = sample_valid_i && (state_q == FR_RUN) && !start_i;
  assign last_take = accept_o && (count_q == LAST_IDX);
  assign ready_o   = ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_IDLE;
      count_q <= '0;
      ready_q <= 1'b0;
    end else if (start_i) begin
      state_q <= FR_RUN;
      count_q <= '0;
      ready_q <= 1'b0;
    end else if (accept_o) begin
      if (last_take) begin
        state_q <= FR_DONE;
        count_q <= '0;
        ready_q <= 1'b1;
      end else begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  // R4: the counter never passes the last index of the frame
  a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST_IDX);

  // R4: ready rises only right after the final sample was taken
  a_r4_ready_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(last_take));

  // R5: ready is sticky until a start
  a_r5_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !start_i) |=> ready_q);

  // R1: a start always drops ready
  a_r1_start_drops_ready: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !ready_q);

  // R3: no sample is taken while a finished frame is shown
  a_r3_no_take_when_ready: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> !accept_o);

endmodule

// File: rtl/acorr_tap_line.sv
module acorr_tap_line #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_i,
  input  logic                      shift_i,
  input  logic [SAMPLE_W-1:0]       din_i,
  output logic [DEPTH*SAMPLE_W-1:0] taps_o
);

  logic [SAMPLE_W-1:0] tap_q [DEPTH];

  generate
    for (genvar j = 0; j < DEPTH; j++) begin : g_tap
      logic [SAMPLE_W-1:0] feed;
      if (j == 0) begin : g_head
        assign feed = din_i;
      end else begin : g_body
        assign feed = tap_q[j-1];
      end

      always_ff @(posedge clk) begin
        if (rst || clr_i) begin
          tap_q[j] <= '0;
        end else if (shift_i) begin
          tap_q[j] <= feed;
        end
      end

      assign taps_o[j*SAMPLE_W +: SAMPLE_W] = tap_q[j];
    end
  endgenerate

  // R6: a clear empties the whole history
  a_r6_taps_cleared: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (taps_o == '0));

  // R3: without a shift the history stays put
  a_r3_taps_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !shift_i) |=> $stable(taps_o));

endmodule

// File: rtl/acorr_mac_cell.sv
module acorr_mac_cell #(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] a_i,
  input  logic [SAMPLE_W-1:0] b_i,
  output logic [ACC_W-1:0]    acc_o
);

  localparam int PROD_W = 2 * SAMPLE_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;
  logic        [ACC_W-1:0]  prod_ext;
  logic        [ACC_W-1:0]  acc_q;

  assign prod     = $signed(a_i) * $signed(b_i);
  assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      acc_q <= '0;
    end else if (en_i) begin
      acc_q <= acc_q + prod_ext;
    end
  end

  assign acc_o = acc_q;

  // R1: a clear leaves the sum at zero
  a_r1_cell_cleared: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (acc_o == '0));

  // R5: without an enable the sum does not move
  a_r5_cell_holds: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !en_i) |=> $stable(acc_o));

endmodule

// File: rtl/acorr_systolic.sv
module acorr_systolic #(
  parameter int SAMPLE_W  = 16,
  parameter int ACC_W     = 40,
  parameter int NUM_LAGS  = 10,
  parameter int FRAME_LEN = 240
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      sample_valid_i,
  input  logic [SAMPLE_W-1:0]       sample_i,
  output logic                      ready_o,
  output logic [NUM_LAGS*ACC_W-1:0] lag_o
);

  localparam int TAP_DEPTH = NUM_LAGS - 1;

  logic                       accept;
  logic                       clear;
  logic [TAP_DEPTH*SAMPLE_W-1:0] taps;

  acorr_frame_ctrl #(
    .FRAME_LEN(FRAME_LEN)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .sample_valid_i(sample_valid_i),
    .accept_o      (accept),
    .clear_o       (clear),
    .ready_o       (ready_o)
  );

  acorr_tap_line #(
    .SAMPLE_W(SAMPLE_W),
    .DEPTH   (TAP_DEPTH)
  ) u_taps (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clear),
    .shift_i(accept),
    .din_i  (sample_i),
    .taps_o (taps)
  );

  generate
    for (genvar k = 0; k < NUM_LAGS; k++) begin : g_cell
      logic [SAMPLE_W-1:0] delayed;
      if (k == 0) begin : g_self
        assign delayed = sample_i;
      end else begin : g_lag
        assign delayed = taps[(k-1)*SAMPLE_W +: SAMPLE_W];
      end

      acorr_mac_cell #(
        .SAMPLE_W(SAMPLE_W),
        .ACC_W   (ACC_W)
      ) u_mac (
        .clk  (clk),
        .rst  (rst),
        .clr_i(clear),
        .en_i (accept),
        .a_i  (sample_i),
        .b_i  (delayed),
        .acc_o(lag_o[k*ACC_W +: ACC_W])
      );
    end
  endgenerate

  // R5: a finished frame is frozen until the next start
  a_r5_result_frozen: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !start_i) |=> $stable(lag_o));

  // R9: out of reset the outputs are empty
  a_r9_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!ready_o && (lag_o == '0)));

endmodule

// File: tb/acorr_systolic_tb.sv
`timescale 1ns/1ps
module acorr_systolic_tb;

  localparam int SW = 16;
  localparam int AW = 40;
  localparam int NL = 10;
  localparam int FL = 240;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              sample_valid_i = 1'b0;
  logic [SW-1:0]     sample_i = '0;
  logic              ready_o;
  logic [NL*AW-1:0]  lag_o;

  int errors = 0;
  int checks = 0;

  logic signed [SW-1:0] frame [FL];
  longint               expv  [NL];
  int unsigned          seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  acorr_systolic #(
    .SAMPLE_W(SW), .ACC_W(AW), .NUM_LAGS(NL), .FRAME_LEN(FL)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sample_valid_i(sample_valid_i),
    .sample_i(sample_i), .ready_o(ready_o), .lag_o(lag_o)
  );

  function automatic longint lag_val(int k);
    logic signed [AW-1:0] v;
    v = lag_o[k*AW +: AW];
    return longint'(v);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic model();
    for (int k = 0; k < NL; k++) begin
      expv[k] = 0;
      for (int n = k; n < FL; n++) expv[k] += longint'(frame[n]) * longint'(frame[n-k]);
    end
  endtask

  task automatic check_lags(input string req);
    for (int k = 0; k < NL; k++) check(lag_val(k) == expv[k], req, lag_val(k), expv[k]);
  endtask

  task automatic pulse_start(input bit with_valid);
    @(negedge clk);
    start_i = 1'b1;
    sample_valid_i = with_valid;
    sample_i = 16'h7FFF;
    @(negedge clk);
    start_i = 1'b0;
    sample_valid_i = 1'b0;
  endtask

  // Streams the frame; gap_mode inserts idle cycles. Checks R4 timing.
  task automatic stream(input bit gap_mode);
    for (int i = 0; i < FL; i++) begin
      if (gap_mode && (i % 7 == 3)) begin
        sample_valid_i = 1'b0;
        sample_i = 16'h5A5A;
        @(negedge clk);
      end
      sample_valid_i = 1'b1;
      sample_i = frame[i];
      if (i == FL - 1) check(ready_o == 1'b0, "R4 ready early", longint'(ready_o), 0);
      @(negedge clk);
    end
    sample_valid_i = 1'b0;
    check(ready_o == 1'b1, "R4 ready late", longint'(ready_o), 1);
  endtask

  task automatic fill_lcg();
    for (int i = 0; i < FL; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      frame[i] = seed[30:15];
    end
  endtask

  task automatic t_reset();
    check(ready_o == 1'b0, "R9 ready", longint'(ready_o), 0);
    for (int k = 0; k < NL; k++) check(lag_val(k) == 0, "R9 lag", lag_val(k), 0);
    // R3: strobes with no open frame
    for (int i = 0; i < 5; i++) begin
      sample_valid_i = 1'b1; sample_i = 16'h4000; @(negedge clk);
    end
    sample_valid_i = 1'b0;
    check(ready_o == 1'b0, "R3 idle ready", longint'(ready_o), 0);
    check(lag_val(0) == 0, "R3 idle lag0", lag_val(0), 0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < FL; i++) frame[i] = 16'(i - 120);
    model();
    pulse_start(1'b0);
    stream(1'b0);
    check_lags("R2 ramp");
  endtask

  task automatic t_gaps_then_ignore();
    fill_lcg();
    model();
    pulse_start(1'b0);
    stream(1'b1);
    check_lags("R3 gaps");
    for (int i = 0; i < 8; i++) begin
      sample_valid_i = 1'b1; sample_i = 16'h8001; @(negedge clk);
    end
    sample_valid_i = 1'b0;
    check(ready_o == 1'b1, "R5 ready held", longint'(ready_o), 1);
    check_lags("R5 held");
  endtask

  task automatic t_restart();
    pulse_start(1'b0);
    for (int i = 0; i < 100; i++) begin
      sample_valid_i = 1'b1; sample_i = 16'h7000; @(negedge clk);
    end
    sample_valid_i = 1'b0;
    fill_lcg();
    model();
    pulse_start(1'b0);
    stream(1'b0);
    check_lags("R6 restart");
  endtask

  task automatic t_start_with_valid();
    for (int i = 0; i < FL; i++) frame[i] = 16'((i * 37) % 201 - 100);
    model();
    pulse_start(1'b1);
    stream(1'b0);
    check_lags("R7 start strobe");
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < FL; i++) frame[i] = 16'sh8000;
    pulse_start(1'b0);
    stream(1'b1);
    for (int k = 0; k < NL; k++)
      check(lag_val(k) == longint'(FL - k) * 64'sd1073741824, "R8 full scale",
            lag_val(k), longint'(FL - k) * 64'sd1073741824);
  endtask

  task automatic t_clear();
    pulse_start(1'b0);
    check(ready_o == 1'b0, "R1 ready cleared", longint'(ready_o), 0);
    for (int k = 0; k < NL; k++) check(lag_val(k) == 0, "R1 lag cleared", lag_val(k), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ramp();
    t_gaps_then_ignore();
    t_restart();
    t_start_with_valid();
    t_full_scale();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule